// File: doc/BRIEF.md
# Configuration Register Target with Single-Phase Disconnect

This block is the target side of configuration-space accesses. It holds a bank of 64 configuration words and selects one of them with address bits 7 to 2. The two lowest address bits play no part in the selection. A read hands back the whole selected word. A write merges new data into the selected word one byte at a time, under active-low byte enables. A fixed per-bit read-only mask protects bits that software must never change.

Burst configuration accesses are not supported. Each transaction is served for exactly one data phase. The requester marks whether that phase is its last. If it is not, the block signals a disconnect in the same cycle that it completes the phase, and the requester must then end the transaction. A small controller sequences every access through three named states:

- `ST_IDLE` waits for a start strobe. Transition T_ACCEPT moves it to `ST_ACCESS` and captures the request.
- `ST_ACCESS` commits the write or fetches the read word. Transition T_COMMIT moves it to `ST_RESPOND`.
- `ST_RESPOND` presents the completion for one cycle. Transition T_RETIRE returns it to `ST_IDLE`.

While the controller is not in `ST_IDLE`, a start strobe is not looked at.

Top module: `cfg_target`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_disconnect` and `rsp_rdata` are 0. Word 0 holds the parameter `ID_WORD` (default 32'hC0DE_0A11) and every other word holds 0.
- R2: A read returns the word selected by `cfg_addr[7:2]`, and the value of `cfg_addr[1:0]` does not change which word is read.
- R3: On a write, `cfg_be_n[k]` low replaces bits 8k+7..8k of the word with the same bits of `cfg_wdata`, and `cfg_be_n[k]` high leaves them unchanged.
- R4: A write with `cfg_be_n` = 4'b1111 leaves the addressed word unchanged.
- R5: Read-only bits keep their value through any write: all 32 bits of word 0, and bits 31..16 of word 1.
- R6: A start sampled in `ST_IDLE` at clock edge k makes `rsp_valid` high for exactly the one cycle between edges k+1 and k+2. `rsp_valid` is high at no other time.
- R7: `rsp_disconnect` is high exactly when `rsp_valid` is high and `cfg_last` was low at the accepted start. This applies to reads and writes alike.
- R8: `rsp_rdata` carries the read word while `rsp_valid` is high for a read. At all other times, and for writes, it is 0.
- R9: A start raised while a transaction is in `ST_ACCESS` or `ST_RESPOND` is ignored: it produces no completion and writes nothing.
- R10: A write is visible to a read whose start is accepted after the write's completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_start | input | 1 | Start strobe; the request fields below are sampled with it |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 8 | Byte address; bits 7..2 select the word |
| cfg_wdata | input | 32 | Write data |
| cfg_be_n | input | 4 | Byte enables, active low |
| cfg_last | input | 1 | The presented data phase is the final one |
| rsp_valid | output | 1 | Data phase completes this cycle |
| rsp_rdata | output | 32 | Read data, 0 when not a read completion |
| rsp_disconnect | output | 1 | Transaction must end after this phase |

## Verification
A phase completion and a disconnect can land in the same cycle, and partial byte merging and disconnect can coincide on the same write. The bench provokes these overlaps with reads and writes whose last flag is low, including a write with only some byte enables active. It then checks that completion, disconnect and zero read data appear together. A later read checks that the merged bytes, the read-only bits and any ignored overlapping start have all left the expected word contents. A behavioural model judges every cycle, and directed checks against fixed values back it up.

// File: rtl/cfg_target_pkg.sv
package cfg_target_pkg;

    localparam int CFG_ADDR_W = 8;
    localparam int CFG_DATA_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_RESPOND = 2'd2
    } cfg_state_e;

endpackage

// File: rtl/cfg_decode.sv
module cfg_decode #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W/8-1:0]         be_n,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] idx,
    output logic [DATA_W-1:0]           bmask
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    // word select drops the byte offset bits
    assign idx = addr[ADDR_W-1:OFF_W];

    // each active-low enable widens to a full byte of mask
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign bmask[8*b +: 8] = {8{~be_n[b]}};
    end

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
    parameter int          DATA_W  = 32,
    parameter int          IDX_W   = 6,
    parameter logic [31:0] ID_WORD = 32'hC0DE_0A11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] wr_bmask,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NUM_WORDS = 1 << IDX_W;
    localparam int HALF_W    = DATA_W / 2;

    function automatic logic [DATA_W-1:0] ro_bits(input int i);
        logic [DATA_W-1:0] m;
        m = '0;
        if (i == 0) begin
            m = '1;
        end else if (i == 1) begin
            m[DATA_W-1:HALF_W] = '1;
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] reset_bits(input int i);
        return (i == 0) ? DATA_W'(ID_WORD) : '0;
    endfunction

    logic [NUM_WORDS-1:0][DATA_W-1:0] words;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        localparam logic [DATA_W-1:0] RO_M  = ro_bits(g);
        localparam logic [DATA_W-1:0] RST_V = reset_bits(g);
        logic              sel;
        logic [DATA_W-1:0] keep_m;
        logic [DATA_W-1:0] q;

        assign sel    = wr_en && (wr_idx == IDX_W'(g));
        assign keep_m = RO_M | ~wr_bmask;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= RST_V;
            end else if (sel) begin
                q <= (q & keep_m) | (wr_data & ~keep_m);
            end
        end

        assign words[g] = q;
    end

    assign rd_data = words[rd_idx];

endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
    import cfg_target_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_write,
    input  logic              last,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] req_bmask,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] mem_bmask,
    output logic              rsp_valid,
    output logic              rsp_disconnect,
    output logic [DATA_W-1:0] rsp_rdata
);
    cfg_state_e state_q, state_d;

    logic              wr_q;
    logic              last_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] bmask_q;
    logic [DATA_W-1:0] rd_q;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && start;

    // next-state logic: T_ACCEPT, T_COMMIT, T_RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_ACCESS;
            ST_ACCESS:  state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request capture and read-word latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            last_q  <= 1'b1;
            idx_q   <= '0;
            wdata_q <= '0;
            bmask_q <= '0;
            rd_q    <= '0;
        end else begin
            if (accept) begin
                wr_q    <= is_write;
                last_q  <= last;
                idx_q   <= req_idx;
                wdata_q <= req_wdata;
                bmask_q <= req_bmask;
            end
            if (state_q == ST_ACCESS) begin
                rd_q <= wr_q ? '0 : mem_rdata;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        mem_we         = 1'b0;
        rsp_valid      = 1'b0;
        rsp_disconnect = 1'b0;
        rsp_rdata      = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ACCESS: begin
                mem_we = wr_q;
            end
            ST_RESPOND: begin
                rsp_valid      = 1'b1;
                rsp_disconnect = ~last_q;
                rsp_rdata      = rd_q;
            end
            default: begin
            end
        endcase
    end

    assign mem_idx   = idx_q;
    assign mem_wdata = wdata_q;
    assign mem_bmask = bmask_q;

endmodule

// File: rtl/cfg_target.sv
module cfg_target
    import cfg_target_pkg::*;
#(
    parameter int          ADDR_W  = CFG_ADDR_W,
    parameter int          DATA_W  = CFG_DATA_W,
    parameter logic [31:0] ID_WORD = 32'hC0DE_0A11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start,
    input  logic              cfg_write,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [DATA_W/8-1:0] cfg_be_n,
    input  logic              cfg_last,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_disconnect
);
    localparam int LANES = DATA_W / 8;
    localparam int IDX_W = ADDR_W - $clog2(LANES);

    logic [IDX_W-1:0]  dec_idx;
    logic [DATA_W-1:0] dec_bmask;
    logic              mem_we;
    logic [IDX_W-1:0]  mem_idx;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_bmask;
    logic [DATA_W-1:0] mem_rdata;

    cfg_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .addr  (cfg_addr),
        .be_n  (cfg_be_n),
        .idx   (dec_idx),
        .bmask (dec_bmask)
    );

    cfg_ctrl #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (cfg_start),
        .is_write       (cfg_write),
        .last           (cfg_last),
        .req_idx        (dec_idx),
        .req_wdata      (cfg_wdata),
        .req_bmask      (dec_bmask),
        .mem_rdata      (mem_rdata),
        .mem_we         (mem_we),
        .mem_idx        (mem_idx),
        .mem_wdata      (mem_wdata),
        .mem_bmask      (mem_bmask),
        .rsp_valid      (rsp_valid),
        .rsp_disconnect (rsp_disconnect),
        .rsp_rdata      (rsp_rdata)
    );

    cfg_regfile #(
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W),
        .ID_WORD (ID_WORD)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mem_we),
        .wr_idx   (mem_idx),
        .wr_data  (mem_wdata),
        .wr_bmask (mem_bmask),
        .rd_idx   (mem_idx),
        .rd_data  (mem_rdata)
    );

endmodule

// File: rtl/cfg_target_chk.sv
module cfg_target_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_start,
    input logic              cfg_last,
    input logic              rsp_valid,
    input logic              rsp_disconnect,
    input logic [DATA_W-1:0] rsp_rdata
);
    // R6: a completion lasts one cycle
    p_rsp_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6: every completion traces back to a start two edges earlier
    p_rsp_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cfg_start, 2));

    // R7: no disconnect outside a completion
    p_disc_in_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_disconnect |-> rsp_valid);

    // R7: final phase completes without disconnect
    p_disc_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(cfg_last, 2)) |-> !rsp_disconnect);

    // R7: non-final phase completes with disconnect
    p_disc_more_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(cfg_last, 2)) |-> rsp_disconnect);

    // R8: read data bus is quiet outside completions
    p_rdata_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_rdata == '0));

endmodule

bind cfg_target cfg_target_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_start      (cfg_start),
    .cfg_last       (cfg_last),
    .rsp_valid      (rsp_valid),
    .rsp_disconnect (rsp_disconnect),
    .rsp_rdata      (rsp_rdata)
);

// File: tb/cfg_target_test.sv
module cfg_target_test;

    localparam logic [31:0] ID_V = 32'hC0DE_0A11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_start = 1'b0;
    logic        cfg_write = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  cfg_be_n = 4'hF;
    logic        cfg_last = 1'b1;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_disconnect;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    cfg_target uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_start      (cfg_start),
        .cfg_write      (cfg_write),
        .cfg_addr       (cfg_addr),
        .cfg_wdata      (cfg_wdata),
        .cfg_be_n       (cfg_be_n),
        .cfg_last       (cfg_last),
        .rsp_valid      (rsp_valid),
        .rsp_rdata      (rsp_rdata),
        .rsp_disconnect (rsp_disconnect)
    );

    // behavioural reference model
    logic [31:0] m_mem [64];
    int          m_phase = 0;
    logic        m_wr, m_last;
    logic [7:0]  m_addr;
    logic [31:0] m_wdata;
    logic [3:0]  m_be_n;
    logic        e_rsp = 1'b0;
    logic        e_disc = 1'b0;
    logic [31:0] e_rdata = '0;

    function automatic logic [31:0] m_ro(input int i);
        if (i == 0) return 32'hFFFF_FFFF;
        if (i == 1) return 32'hFFFF_0000;
        return 32'h0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) m_mem[i] = (i == 0) ? ID_V : 32'h0;
            m_phase = 0;
            e_rsp = 1'b0; e_disc = 1'b0; e_rdata = '0;
        end else begin
            int was_idle;
            was_idle = (m_phase == 0);
            if (m_phase == 1) begin
                int w;
                w = int'(m_addr[7:2]);
                e_rsp   = 1'b1;
                e_disc  = !m_last;
                e_rdata = m_wr ? 32'h0 : m_mem[w];
                if (m_wr) begin
                    for (int b = 0; b < 4; b++) begin
                        for (int k = 0; k < 8; k++) begin
                            if (!m_be_n[b] && !m_ro(w)[8*b+k])
                                m_mem[w][8*b+k] = m_wdata[8*b+k];
                        end
                    end
                end
                m_phase = 2;
            end else if (m_phase == 2) begin
                e_rsp = 1'b0; e_disc = 1'b0; e_rdata = '0;
                m_phase = 0;
            end
            if (was_idle && cfg_start) begin
                m_wr = cfg_write; m_last = cfg_last; m_addr = cfg_addr;
                m_wdata = cfg_wdata; m_be_n = cfg_be_n;
                m_phase = 1;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_tests++;
            if (rsp_valid !== e_rsp) begin
                n_fail++;
                $display("FAIL R6 cycle rsp_valid act=%b exp=%b", rsp_valid, e_rsp);
            end
            n_tests++;
            if (rsp_disconnect !== e_disc) begin
                n_fail++;
                $display("FAIL R7 cycle rsp_disconnect act=%b exp=%b", rsp_disconnect, e_disc);
            end
            n_tests++;
            if (rsp_rdata !== e_rdata) begin
                n_fail++;
                $display("FAIL R8 cycle rsp_rdata act=%h exp=%h", rsp_rdata, e_rdata);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one transaction; samples the completion cycle
    task automatic txn(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [3:0] be, input logic lst,
                       output logic [31:0] rd, output logic rv, output logic dc);
        @(negedge clk);
        cfg_start = 1'b1; cfg_write = wr; cfg_addr = a;
        cfg_wdata = d; cfg_be_n = be; cfg_last = lst;
        @(negedge clk);
        cfg_start = 1'b0;
        @(negedge clk);
        rd = rsp_rdata; rv = rsp_valid; dc = rsp_disconnect;
    endtask

    task automatic rd_word(input logic [7:0] a, output logic [31:0] v);
        logic rv, dc;
        txn(1'b0, a, 32'h0, 4'h0, 1'b1, v, rv, dc);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic rv, dc;
        repeat (3) @(negedge clk);
        check("R1 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
        check("R1 reset disconnect", {31'h0, rsp_disconnect}, 32'h0);
        check("R1 reset rdata", rsp_rdata, 32'h0);
        rst_n = 1'b1;

        rd_word(8'h00, v); check("R1 word0 reset value", v, ID_V);
        rd_word(8'h08, v); check("R1 word2 reset value", v, 32'h0);

        txn(1'b1, 8'h08, 32'hA5A5_5A5A, 4'h0, 1'b1, v, rv, dc);
        check("R6 write completes", {31'h0, rv}, 32'h1);
        check("R7 last write no disconnect", {31'h0, dc}, 32'h0);
        rd_word(8'h08, v); check("R10 write visible", v, 32'hA5A5_5A5A);
        rd_word(8'h0B, v); check("R2 offset bits ignored", v, 32'hA5A5_5A5A);

        // partial write, not last: completion and disconnect together
        txn(1'b1, 8'h08, 32'h1122_3344, 4'b1010, 1'b0, v, rv, dc);
        check("R7 write disconnect with completion", {30'h0, rv, dc}, 32'h3);
        check("R8 write returns zero data", v, 32'h0);
        rd_word(8'h08, v); check("R3 byte merge", v, 32'hA522_5A44);

        txn(1'b1, 8'h08, 32'hFFFF_FFFF, 4'hF, 1'b1, v, rv, dc);
        rd_word(8'h08, v); check("R4 no enables no change", v, 32'hA522_5A44);

        txn(1'b1, 8'h00, 32'h0000_0000, 4'h0, 1'b1, v, rv, dc);
        rd_word(8'h00, v); check("R5 word0 read-only", v, ID_V);
        txn(1'b1, 8'h04, 32'hDEAD_BEEF, 4'h0, 1'b1, v, rv, dc);
        rd_word(8'h04, v); check("R5 word1 upper half read-only", v, 32'h0000_BEEF);

        rd_word(8'hFC, v); check("R2 top word reset", v, 32'h0);
        txn(1'b1, 8'hFE, 32'h1234_5678, 4'h0, 1'b0, v, rv, dc);
        rd_word(8'hFC, v); check("R2 top word written", v, 32'h1234_5678);

        // read not last: data and disconnect in the same cycle
        txn(1'b0, 8'h08, 32'h0, 4'h0, 1'b0, v, rv, dc);
        check("R7 read disconnect", {30'h0, rv, dc}, 32'h3);
        check("R8 read data with disconnect", v, 32'hA522_5A44);

        // start held through busy states must be ignored
        @(negedge clk);
        cfg_start = 1'b1; cfg_write = 1'b1; cfg_addr = 8'h14;
        cfg_wdata = 32'h0000_0055; cfg_be_n = 4'h0; cfg_last = 1'b1;
        @(negedge clk);
        cfg_addr = 8'h18; cfg_wdata = 32'h0000_0066;
        @(negedge clk);
        check("R6 busy first completion", {31'h0, rsp_valid}, 32'h1);
        cfg_start = 1'b0;
        @(negedge clk);
        check("R9 no extra completion", {31'h0, rsp_valid}, 32'h0);
        rd_word(8'h18, v); check("R9 busy start wrote nothing", v, 32'h0);
        rd_word(8'h14, v); check("R10 accepted write kept", v, 32'h0000_0055);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule